// File: doc/BRIEF.md
# Cyclic-Shift Spreading Code Generator

This block turns a stream of 4-bit data symbols into serial spreading chips. A single root word is held as a constant. Every one of the 16 codewords is built from that root when a symbol is accepted: the root is rotated cyclically, and the chips at odd positions are optionally inverted. No 16-entry codeword table exists. A build parameter selects the 8-chip code or the 16-chip code.

Symbols arrive on a valid/ready handshake. Chips leave one per pulse of an external chip-enable input. A chip-valid flag and a start-of-symbol flag accompany each chip. The chip-enable pulse sets the chip rate. Nominal rates are 300 kchip/s for the 8-chip code and 1 Mchip/s for the 16-chip code. A transmit chain places this block ahead of pulse shaping and modulation, which are not part of it.

Top module: `cs_spreader`

## Requirements
- R1: Symbol value 0 emits the unmodified root word, most significant chip first. The root is 0x5C when CHIPS=8 and 0x2F53 when CHIPS=16.
- R2: With CHIPS=8, symbol bits [2:0] give a right-rotation amount k and bit 3 selects inversion. The chip at transmit position i (0 = first) equals root chip ((i-k) mod 8), inverted when the inversion bit is set and i is odd.
- R3: With CHIPS=16, the rotation amount is k = 2*sym[3:1] and bit 0 selects inversion. Chip i equals root chip ((i-k) mod 16), inverted when the inversion bit is set and i is odd.
- R4: Exactly one chip is emitted for each chip_en pulse, in transmit order. Between pulses, chip_out, chip_valid and chip_sos keep their values.
- R5: chip_valid is 1 for every chip of a symbol. chip_sos is 1 only with the first chip, which is emitted on the same chip_en pulse that accepts the symbol.
- R6: sym_ready is 1 exactly when the block is out of reset, chip_en is 1, and no chip of the current symbol remains to be emitted. A symbol is taken when sym_valid and sym_ready are both 1.
- R7: A new symbol can be taken on the chip_en pulse right after the last chip of the previous one, so consecutive symbols leave no gap in the chip stream.
- R8: On a chip_en pulse with no chip remaining and no symbol offered, chip_valid becomes 0 and chip_out and chip_sos become 0.
- R9: While rst_n is 0, chip_out, chip_valid, chip_sos and sym_ready read 0 after the next clock edge.
- R10: While a symbol is being sent, sym_valid and sym_data have no effect on the chips of that symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en | input | 1 | Chip-rate pulse; each pulse advances one chip |
| sym_valid | input | 1 | Symbol offered |
| sym_data | input | 4 | Symbol value |
| sym_ready | output | 1 | Symbol taken this cycle if valid |
| chip_out | output | 1 | Current chip |
| chip_valid | output | 1 | chip_out belongs to a symbol |
| chip_sos | output | 1 | First chip of a symbol |

## Verification
On every cycle, the assertions check the following:
- sym_ready rises only with chip_en and never while chips remain.
- The outputs hold steady between chip_en pulses.
- An idle output is all zero.
- An accepted symbol always opens with a flagged first chip.

Only the bench scenarios can show whether the chip values match the rotation and inversion rule for every symbol in both code sizes. The same applies to the gapless joins between symbols and to the fact that a symbol offered during a busy period is ignored.

// File: rtl/cs_spreader_pkg.sv
// Package: shared constants and helper functions for the spreading code
// generator. Assumes CHIPS is 8 or 16.
package cs_spreader_pkg;

    localparam int SYM_W = 4;

    // Root word for a code size, MSB = first chip sent.
    function automatic logic [15:0] root_word(input int chips);
        if (chips == 8) return 16'h005C;
        return 16'h2F53;
    endfunction

    // Mask of chips at odd transmit positions (bit chips-1 is position 0).
    function automatic logic [15:0] odd_mask(input int chips);
        logic [15:0] m;
        m = '0;
        for (int p = 1; p < chips; p += 2) m[chips-1-p] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/cs_rotator.sv
// Module: cyclic right rotation of a W-bit word by a run-time amount.
// Assumes amt < W. Purely combinational.
module cs_rotator #(
    parameter int W     = 16,
    parameter int AMT_W = $clog2(W)
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     dout
);
    logic [2*W-1:0] doubled;
    logic [2*W-1:0] shifted;

    // Rotate by shifting a doubled copy and keeping the low half.
    always_comb begin
        doubled = {din, din};
        shifted = doubled >> amt;
        dout    = shifted[W-1:0];
    end
endmodule

// File: rtl/cs_codegen.sv
// Module: builds the codeword for one symbol from the stored root word.
// The symbol is decoded into a rotation amount and an inversion flag. The
// decode depends on CHIPS (8 or 16). Purely combinational.
module cs_codegen
    import cs_spreader_pkg::*;
#(
    parameter int CHIPS = 16
) (
    input  logic [SYM_W-1:0] sym,
    output logic [CHIPS-1:0] code
);
    localparam int AMT_W = $clog2(CHIPS);
    localparam logic [15:0] ROOT_FULL = root_word(CHIPS);
    localparam logic [15:0] MASK_FULL = odd_mask(CHIPS);
    localparam logic [CHIPS-1:0] ROOT = ROOT_FULL[CHIPS-1:0];
    localparam logic [CHIPS-1:0] MASK = MASK_FULL[CHIPS-1:0];

    logic [AMT_W-1:0] amt;
    logic             inv;
    logic [CHIPS-1:0] rotated;

    generate
        if (CHIPS == 8) begin : g_c8
            // 8-chip decode: bits [2:0] rotate, bit 3 inverts.
            always_comb begin
                amt = sym[2:0];
                inv = sym[3];
            end
        end else begin : g_c16
            // 16-chip decode: even rotation from bits [3:1], bit 0 inverts.
            always_comb begin
                amt = {sym[3:1], 1'b0};
                inv = sym[0];
            end
        end
    endgenerate

    cs_rotator #(.W(CHIPS), .AMT_W(AMT_W)) u_rot (
        .din (ROOT),
        .amt (amt),
        .dout(rotated)
    );

    // Apply the optional odd-position inversion.
    always_comb code = rotated ^ (inv ? MASK : '0);
endmodule

// File: rtl/cs_serializer.sv
// Module: shifts a loaded codeword out MSB first, one chip per chip_en.
// Assumes load is only raised with chip_en while idle is high.
module cs_serializer #(
    parameter int CHIPS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             load,
    input  logic [CHIPS-1:0] code_in,
    output logic             chip_out,
    output logic             chip_valid,
    output logic             chip_sos,
    output logic             idle
);
    localparam int CNT_W = $clog2(CHIPS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHIPS - 1);

    logic [CHIPS-1:0] shreg;
    logic [CNT_W-1:0] left;

    // Chips still waiting in the shift register.
    always_comb idle = (left == '0);

    // Advance the chip stream on each chip_en pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            left       <= '0;
            chip_out   <= 1'b0;
            chip_valid <= 1'b0;
            chip_sos   <= 1'b0;
        end else if (chip_en) begin
            if (load) begin
                chip_out   <= code_in[CHIPS-1];
                shreg      <= {code_in[CHIPS-2:0], 1'b0};
                left       <= LAST;
                chip_valid <= 1'b1;
                chip_sos   <= 1'b1;
            end else if (!idle) begin
                chip_out   <= shreg[CHIPS-1];
                shreg      <= {shreg[CHIPS-2:0], 1'b0};
                left       <= left - 1'b1;
                chip_valid <= 1'b1;
                chip_sos   <= 1'b0;
            end else begin
                chip_out   <= 1'b0;
                chip_valid <= 1'b0;
                chip_sos   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cs_spreader.sv
// Module: top of the spreading code generator. Takes 4-bit symbols on a
// valid/ready handshake and emits their codewords serially on chip_en.
// Assumes chip_en is a single-cycle pulse at the chip rate.
module cs_spreader
    import cs_spreader_pkg::*;
#(
    parameter int CHIPS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    output logic             sym_ready,
    output logic             chip_out,
    output logic             chip_valid,
    output logic             chip_sos
);
    logic [CHIPS-1:0] code;
    logic             ser_idle;
    logic             accept;

    // Ready only on a chip tick when the previous symbol is finished.
    always_comb begin
        sym_ready = rst_n && chip_en && ser_idle;
        accept    = sym_valid && sym_ready;
    end

    cs_codegen #(.CHIPS(CHIPS)) u_codegen (
        .sym (sym_data),
        .code(code)
    );

    cs_serializer #(.CHIPS(CHIPS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_en   (chip_en),
        .load      (accept),
        .code_in   (code),
        .chip_out  (chip_out),
        .chip_valid(chip_valid),
        .chip_sos  (chip_sos),
        .idle      (ser_idle)
    );
endmodule

// File: rtl/cs_spreader_chk.sv
// Checker: protocol and output properties of cs_spreader, bound below.
module cs_spreader_chk (
    input logic clk,
    input logic rst_n,
    input logic chip_en,
    input logic sym_valid,
    input logic sym_ready,
    input logic chip_out,
    input logic chip_valid,
    input logic chip_sos,
    input logic idle
);
    AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        sym_ready |-> chip_en); // R6
    AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> !sym_ready); // R10
    AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> ($stable(chip_out) && $stable(chip_valid) && $stable(chip_sos))); // R4
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_valid |-> (!chip_out && !chip_sos)); // R8
    AST_SOS_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready) |=> (chip_sos && chip_valid)); // R5
endmodule

bind cs_spreader cs_spreader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en   (chip_en),
    .sym_valid (sym_valid),
    .sym_ready (sym_ready),
    .chip_out  (chip_out),
    .chip_valid(chip_valid),
    .chip_sos  (chip_sos),
    .idle      (ser_idle)
);

// File: tb/cs_lane_check.sv
// Bench lane: drives one cs_spreader instance and checks its chips against
// a model built from the requirements.
module cs_lane_check #(
    parameter int CHIPS = 16,
    parameter int SEED  = 1,
    parameter int NSYM  = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chip_en,
    output int   n_chk,
    output int   n_bad,
    output logic done
);
    logic       sym_valid;
    logic [3:0] sym_data;
    logic       sym_ready, chip_out, chip_valid, chip_sos;

    cs_spreader #(.CHIPS(CHIPS)) u_cs_spreader (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
        .sym_valid(sym_valid), .sym_data(sym_data), .sym_ready(sym_ready),
        .chip_out(chip_out), .chip_valid(chip_valid), .chip_sos(chip_sos)
    );

    int   q[$];
    logic en_q, acc_q;
    logic last_out, last_val, last_sos, prev_tick_val;
    int   sent, offered, b2b;

    function automatic logic exp_chip(input int sym, input int i);
        logic [15:0] root;
        int k, src;
        logic inv;
        root = (CHIPS == 8) ? 16'h005C : 16'h2F53;
        if (CHIPS == 8) begin k = sym % 8; inv = sym[3]; end
        else begin k = 2 * (sym / 2); inv = sym[0]; end
        src = (i - k + CHIPS) % CHIPS;
        return root[CHIPS-1-src] ^ (inv && (i % 2 == 1));
    endfunction

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s lane%0d: got %0b expected %0b", tag, CHIPS, act, exp);
        end
    endtask

    initial begin
        void'($urandom(SEED));
        sym_valid = 0; sym_data = 0; n_chk = 0; n_bad = 0; done = 0;
        en_q = 0; acc_q = 0; sent = 0; offered = 0; b2b = 0;
        last_out = 0; last_val = 0; last_sos = 0; prev_tick_val = 0;
    end

    // Posedge: ready check and model update on acceptance.
    always @(posedge clk) begin
        en_q = rst_n && chip_en;
        if (rst_n) begin
            chk((q.size() > 0 && sym_valid) ? "R10" : "R6", sym_ready,
                chip_en && q.size() == 0);
            if (sym_valid && sym_ready) begin
                for (int i = 0; i < CHIPS; i++)
                    q.push_back((int'(sym_data) << 2) | ((i == 0) ? 2 : 0)
                                | int'(exp_chip(int'(sym_data), i)));
                sent++;
                acc_q = 1;
            end
        end
    end

    // Negedge: compare outputs, then drive the next stimulus.
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R9", chip_valid, 0); chk("R9", chip_out, 0);
            chk("R9", chip_sos, 0);   chk("R9", sym_ready, 0);
            sym_valid = 0;
        end else begin
            if (en_q) begin
                if (q.size() > 0) begin
                    int e, s;
                    e = q.pop_front();
                    s = e >> 2;
                    if (e[1] && prev_tick_val) b2b++;
                    chk("R5", chip_valid, 1);
                    chk("R5", chip_sos, e[1]);
                    chk((s == 0) ? "R1" : ((CHIPS == 8) ? "R2" : "R3"), chip_out, e[0]);
                end else begin
                    chk("R8", chip_valid, 0); chk("R8", chip_out, 0);
                    chk("R8", chip_sos, 0);
                end
                prev_tick_val = chip_valid;
            end else begin
                chk("R4", chip_out, last_out); chk("R4", chip_valid, last_val);
                chk("R4", chip_sos, last_sos);
            end
            last_out = chip_out; last_val = chip_valid; last_sos = chip_sos;
            if (acc_q) begin sym_valid = 0; acc_q = 0; end
            if (!sym_valid && offered < NSYM) begin
                if (offered < 16) begin
                    sym_valid = 1; sym_data = 4'(offered); offered++;
                end else if ($urandom % 4 != 0) begin
                    sym_valid = 1; sym_data = 4'($urandom % 16); offered++;
                end
            end else if (sym_valid && offered > 16 && ($urandom % 2 == 1)) begin
                sym_data = 4'($urandom % 16);
            end
            if (!done && sent == NSYM && q.size() == 0) begin
                done = 1;
                chk("R7", b2b > 0, 1);
            end
        end
    end
endmodule

// File: tb/cs_spreader_bench.sv
// Bench top: shared clock, reset and chip_en for an 8-chip and a 16-chip lane.
module cs_spreader_bench;
    logic clk = 0, rst_n = 0, chip_en = 0;
    int   chk16, bad16, chk8, bad8, cyc, wd_bad;
    logic done16, done8;

    always #2.5 clk = ~clk;

    cs_lane_check #(.CHIPS(16), .SEED(11), .NSYM(300)) u_lane16 (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
        .n_chk(chk16), .n_bad(bad16), .done(done16));
    cs_lane_check #(.CHIPS(8), .SEED(23), .NSYM(300)) u_lane8 (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
        .n_chk(chk8), .n_bad(bad8), .done(done8));

    // Chip-enable pattern: every cycle, then 1 in 3, then random.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n)         chip_en = 0;
        else if (cyc < 1500) chip_en = 1;
        else if (cyc < 5000) chip_en = (cyc % 3 == 0);
        else                 chip_en = ($urandom % 2 == 1);
    end

    initial begin
        cyc = 0; wd_bad = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        while (!(done16 && done8) && cyc < 150000) @(negedge clk);
        if (!(done16 && done8)) begin
            wd_bad = 1;
            $display("FAIL watchdog: got incomplete run expected all symbols sent");
        end
        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", chk16 + chk8 + wd_bad,
                 bad16 + bad8 + wd_bad);
        $finish;
    end
endmodule